// File: doc/BRIEF.md
# Two-Road Timed Traffic Light Controller

This block controls the signals at a crossing of two roads, north-south and east-west. Each road has a red, a yellow and a green lamp, and the block drives these lamps directly. The controller runs a fixed loop of four phases:

- north-south green
- north-south yellow
- east-west green
- east-west yellow

While one road is showing green or yellow, the other road is held at red. Each phase lasts a set number of one-second ticks. By default a green phase lasts five ticks and a yellow phase lasts one tick.

The tick source is chosen at run time with a 2-bit select input. There are four settings:

- **Internal divider:** a divider on the fast system clock produces a one-cycle enable pulse. It does not create a derived clock.
- **External 1 Hz input:** the input is synchronized, and each of its rising edges gives one tick.
- **Manual push switch:** the switch is synchronized and debounced, and each accepted press gives one tick.
- **Freeze:** no tick is produced, and the lamps hold where they are.

Inside the block, a datapath holds the divider, the synchronizers, the debouncer, the source select and the dwell counter. A control part holds the phase state machine and the lamp decoding. The two parts exchange a small set of strobes.

Top module: `traffic_xing_ctrl`

## Requirements
- R1: The phases follow the loop north-south green, north-south yellow, east-west green, east-west yellow, and then return to north-south green. The loop never skips a phase and never runs backwards.
- R2: A green phase lasts GREEN_TICKS ticks (default 5) and a yellow phase lasts YELLOW_TICKS ticks (default 1). The phase changes on the clock edge that takes the tick completing its dwell, and the dwell count restarts from zero at that same edge. Between ticks, the lamps do not change.
- R3: Each road's lamp output is 3 bits wide: bit 2 is red, bit 1 is yellow and bit 0 is green. Exactly one of the three bits is set at any time.
- R4: The two roads are never both non-red at the same time. Whenever one road shows green or yellow, the other road's output is red (3'b100).
- R5: With srcSel = 0, the internal divider gives one tick every DIV_RATIO clock cycles. The first tick is taken at the DIV_RATIO-th rising edge after the reset edge.
- R6: With srcSel = 1, each rising edge of extPulseIn gives exactly one tick. The tick is taken at the third clock edge, counting the edge that first samples the high level. Holding the input high gives no further ticks.
- R7: With srcSel = 2, stepButton gives one tick per accepted press. A new level is accepted only after the synchronized input has differed from the accepted level for DEBOUNCE_CYCLES consecutive cycles. Shorter bounces are ignored, and releasing the switch gives no tick.
- R8: With srcSel = 3, no tick is produced, and both lamp outputs stay unchanged for as long as this setting holds.
- R9: A synchronous reset, held high for at least one rising edge, puts the controller in north-south green (nsLamp = 3'b001, ewLamp = 3'b100) with the dwell count at zero. Reset overrides every other input.
- R10: Activity on a tick source that is not selected has no effect on the lamps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| srcSel | input | 2 | Tick source: 0 = divider, 1 = external 1 Hz, 2 = manual switch, 3 = no tick |
| extPulseIn | input | 1 | External 1 Hz square wave, asynchronous |
| stepButton | input | 1 | Raw manual push switch, asynchronous, may bounce |
| nsLamp | output | 3 | North-south lamps {red, yellow, green} |
| ewLamp | output | 3 | East-west lamps {red, yellow, green} |

## Verification
The assertions assume that srcSel is a synchronous control that changes only between clock edges. They also assume that reset is held for at least two edges at the start, so that the check on the phase that came before always looks at a defined lamp value. The bench therefore drives srcSel, extPulseIn and stepButton only on falling edges and holds reset for five cycles at start-up. Every level of the external input is held for at least three cycles, so that each edge is seen through the synchronizer. Switch bounces are kept deliberately shorter than the debounce window, and real presses are kept longer than it, so the stimulus exercises both the ignored case and the accepted case.

// File: rtl/xing_pkg.sv
package xing_pkg;

  // Phase order is behaviour: the state machine increments through it.
  typedef enum logic [1:0] {
    PH_NS_GO   = 2'd0,
    PH_NS_WARN = 2'd1,
    PH_EW_GO   = 2'd2,
    PH_EW_WARN = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    SRC_DIVIDER  = 2'd0,
    SRC_EXTERNAL = 2'd1,
    SRC_STEP     = 2'd2,
    SRC_NONE     = 2'd3
  } tickSrc_e;

  // Control to datapath
  typedef struct packed {
    logic reload;     // restart the dwell count
    logic longDwell;  // current phase uses the green dwell
  } ctlStrobes_t;

  // Datapath to control
  typedef struct packed {
    logic tick;       // one-cycle time-base pulse
    logic dwellEnd;   // dwell count sits at its last value
  } dpStrobes_t;

  // Lamp encoding: {red, yellow, green}
  localparam logic [2:0] LAMP_RED    = 3'b100;
  localparam logic [2:0] LAMP_YELLOW = 3'b010;
  localparam logic [2:0] LAMP_GREEN  = 3'b001;

endpackage

// File: rtl/xing_debounce.sv
// Two-flop synchronizer, stability filter and rising-edge detect for a bouncing switch.
module xing_debounce #(
  parameter int STABLE_CYCLES = 240000
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic rise
);
  localparam int CNT_W = (STABLE_CYCLES < 2) ? 1 : $clog2(STABLE_CYCLES);

  logic [1:0]       syncQ;
  logic             accepted;
  logic             acceptedQ;
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      syncQ     <= '0;
      accepted  <= 1'b0;
      acceptedQ <= 1'b0;
      runCnt    <= '0;
    end else begin
      syncQ     <= {syncQ[0], rawIn};
      acceptedQ <= accepted;
      if (syncQ[1] != accepted) begin
        // R7: accept only after the new level held for the full window
        if (runCnt == CNT_W'(STABLE_CYCLES - 1)) begin
          accepted <= syncQ[1];
          runCnt   <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end

  assign rise = accepted & ~acceptedQ;

endmodule

// File: rtl/xing_datapath.sv
// Time base (divider, external sync, debounced switch), source select and dwell counter.
module xing_datapath
  import xing_pkg::*;
#(
  parameter int DIV_RATIO       = 24000000,
  parameter int DEBOUNCE_CYCLES = 240000,
  parameter int GREEN_TICKS     = 5,
  parameter int YELLOW_TICKS    = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  srcSel,
  input  logic        extIn,
  input  logic        stepIn,
  input  ctlStrobes_t ctl,
  output dpStrobes_t  dp
);
  localparam int MAX_DWELL = (GREEN_TICKS > YELLOW_TICKS) ? GREEN_TICKS : YELLOW_TICKS;
  localparam int DWELL_W   = $clog2(MAX_DWELL + 1);

  logic divTick;
  logic extRise;
  logic stepRise;
  logic tick;

  // Internal divider: single-cycle enable, no derived clock (R5)
  generate
    if (DIV_RATIO < 2) begin : gNoDiv
      assign divTick = 1'b1;
    end else begin : gDiv
      localparam int DIV_W = $clog2(DIV_RATIO);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (rst)                                  divCnt <= '0;
        else if (divCnt == DIV_W'(DIV_RATIO - 1)) divCnt <= '0;
        else                                      divCnt <= divCnt + 1'b1;
      end
      assign divTick = (divCnt == DIV_W'(DIV_RATIO - 1));
    end
  endgenerate

  // External 1 Hz: two-flop sync plus one history flop for the edge (R6)
  logic [2:0] extQ;
  always_ff @(posedge clk) begin
    if (rst) extQ <= '0;
    else     extQ <= {extQ[1:0], extIn};
  end
  assign extRise = extQ[1] & ~extQ[2];

  // Manual switch (R7)
  xing_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) stepDb_i (
    .clk  (clk),
    .rst  (rst),
    .rawIn(stepIn),
    .rise (stepRise)
  );

  // Source select (R8, R10)
  always_comb begin
    unique case (tickSrc_e'(srcSel))
      SRC_DIVIDER:  tick = divTick;
      SRC_EXTERNAL: tick = extRise;
      SRC_STEP:     tick = stepRise;
      default:      tick = 1'b0;
    endcase
  end

  // Dwell counter: counts ticks spent in the current phase (R2)
  logic [DWELL_W-1:0] dwellCnt;
  logic [DWELL_W-1:0] dwellLast;

  assign dwellLast = ctl.longDwell ? DWELL_W'(GREEN_TICKS - 1) : DWELL_W'(YELLOW_TICKS - 1);

  always_ff @(posedge clk) begin
    if (rst)             dwellCnt <= '0;
    else if (ctl.reload) dwellCnt <= '0;
    else if (tick)       dwellCnt <= dwellCnt + 1'b1;
  end

  assign dp.tick     = tick;
  assign dp.dwellEnd = (dwellCnt == dwellLast);

endmodule

// File: rtl/xing_phase_ctrl.sv
// Phase state machine and lamp decode.
module xing_phase_ctrl
  import xing_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  dpStrobes_t  dp,
  output ctlStrobes_t ctl,
  output logic [2:0]  nsLamp,
  output logic [2:0]  ewLamp
);
  phase_e phase;
  logic   advance;

  assign advance       = dp.tick & dp.dwellEnd;
  assign ctl.reload    = advance;
  assign ctl.longDwell = (phase == PH_NS_GO) || (phase == PH_EW_GO);

  // R1, R9: fixed loop, reset to north-south green
  always_ff @(posedge clk) begin
    if (rst)          phase <= PH_NS_GO;
    else if (advance) phase <= phase_e'(phase + 2'd1);
  end

  // R3, R4: one lamp per road; the resting road is always red
  always_comb begin
    unique case (phase)
      PH_NS_GO:   begin nsLamp = LAMP_GREEN;  ewLamp = LAMP_RED;    end
      PH_NS_WARN: begin nsLamp = LAMP_YELLOW; ewLamp = LAMP_RED;    end
      PH_EW_GO:   begin nsLamp = LAMP_RED;    ewLamp = LAMP_GREEN;  end
      default:    begin nsLamp = LAMP_RED;    ewLamp = LAMP_YELLOW; end
    endcase
  end

endmodule

// File: rtl/traffic_xing_ctrl.sv
module traffic_xing_ctrl
  import xing_pkg::*;
#(
  parameter int DIV_RATIO       = 24000000,
  parameter int DEBOUNCE_CYCLES = 240000,
  parameter int GREEN_TICKS     = 5,
  parameter int YELLOW_TICKS    = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] srcSel,
  input  logic       extPulseIn,
  input  logic       stepButton,
  output logic [2:0] nsLamp,
  output logic [2:0] ewLamp
);
  ctlStrobes_t ctlS;
  dpStrobes_t  dpS;

  xing_datapath #(
    .DIV_RATIO      (DIV_RATIO),
    .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
    .GREEN_TICKS    (GREEN_TICKS),
    .YELLOW_TICKS   (YELLOW_TICKS)
  ) datapath_i (
    .clk   (clk),
    .rst   (rst),
    .srcSel(srcSel),
    .extIn (extPulseIn),
    .stepIn(stepButton),
    .ctl   (ctlS),
    .dp    (dpS)
  );

  xing_phase_ctrl control_i (
    .clk   (clk),
    .rst   (rst),
    .dp    (dpS),
    .ctl   (ctlS),
    .nsLamp(nsLamp),
    .ewLamp(ewLamp)
  );

endmodule

// File: rtl/xing_ctrl_checker.sv
module xing_ctrl_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] srcSel,
  input logic [2:0] nsLamp,
  input logic [2:0] ewLamp
);
  AST_NS_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
    $countones(nsLamp) == 1);                                                  // R3
  AST_EW_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
    $countones(ewLamp) == 1);                                                  // R3
  AST_NO_CONFLICT: assert property (@(posedge clk) disable iff (rst)
    nsLamp[2] || ewLamp[2]);                                                   // R4
  AST_NS_WARN_FROM_GO: assert property (@(posedge clk) disable iff (rst)
    (nsLamp == 3'b010 && $past(nsLamp) != 3'b010) |-> $past(nsLamp) == 3'b001); // R1
  AST_EW_WARN_FROM_GO: assert property (@(posedge clk) disable iff (rst)
    (ewLamp == 3'b010 && $past(ewLamp) != 3'b010) |-> $past(ewLamp) == 3'b001); // R1
  AST_NS_GO_AFTER_EW_WARN: assert property (@(posedge clk) disable iff (rst)
    (nsLamp == 3'b001 && $past(nsLamp) != 3'b001 && !$past(rst))
      |-> $past(ewLamp) == 3'b010);                                            // R1
  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (srcSel == 2'd3) |=> ($stable(nsLamp) && $stable(ewLamp)));                // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (nsLamp == 3'b001 && ewLamp == 3'b100));                           // R9
endmodule

bind traffic_xing_ctrl xing_ctrl_checker chk_i (
  .clk   (clk),
  .rst   (rst),
  .srcSel(srcSel),
  .nsLamp(nsLamp),
  .ewLamp(ewLamp)
);

// File: tb/traffic_xing_ctrl_tb_top.sv
module traffic_xing_ctrl_tb_top;
  localparam int DIV = 10;
  localparam int DB  = 4;
  localparam int GT  = 5;
  localparam int YT  = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] srcSel = 2'd0;
  logic       extPulseIn = 1'b0;
  logic       stepButton = 1'b0;
  logic [2:0] nsLamp;
  logic [2:0] ewLamp;

  int    compared = 0;
  int    mismatched = 0;
  int    cycles = 0;
  bit    started = 0;
  string curTag = "R9 reset";

  always #4 clk = ~clk;

  traffic_xing_ctrl #(
    .DIV_RATIO(DIV), .DEBOUNCE_CYCLES(DB), .GREEN_TICKS(GT), .YELLOW_TICKS(YT)
  ) dut_i (
    .clk(clk), .rst(rst), .srcSel(srcSel), .extPulseIn(extPulseIn),
    .stepButton(stepButton), .nsLamp(nsLamp), .ewLamp(ewLamp)
  );

  // Behavioural reference state
  int mDiv, mPhase, mElapsed, mRun;
  bit mE1, mE2, mE3, mS1, mS2, mAcc, mPrev;

  function automatic int dwellOf(int ph);
    return (ph % 2 == 0) ? GT : YT;
  endfunction

  function automatic logic [2:0] expNs(int ph);
    case (ph)
      0:       return 3'b001;
      1:       return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  function automatic logic [2:0] expEw(int ph);
    case (ph)
      2:       return 3'b001;
      3:       return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin : modelUpd
    bit tDiv, tExt, tSw, tk;
    started = 1;
    cycles++;
    if (rst) begin
      mDiv = 0; mPhase = 0; mElapsed = 0; mRun = 0;
      mE1 = 0; mE2 = 0; mE3 = 0; mS1 = 0; mS2 = 0; mAcc = 0; mPrev = 0;
    end else begin
      tDiv = (mDiv == DIV - 1);
      tExt = mE2 & ~mE3;
      tSw  = mAcc & ~mPrev;
      case (srcSel)
        2'd0:    tk = tDiv;
        2'd1:    tk = tExt;
        2'd2:    tk = tSw;
        default: tk = 0;
      endcase
      mDiv = (mDiv + 1) % DIV;
      mE3 = mE2; mE2 = mE1; mE1 = extPulseIn;
      mPrev = mAcc;
      if (mS2 != mAcc) begin
        mRun++;
        if (mRun == DB) begin mAcc = mS2; mRun = 0; end
      end else begin
        mRun = 0;
      end
      mS2 = mS1; mS1 = stepButton;
      if (tk) begin
        if (mElapsed == dwellOf(mPhase) - 1) begin
          mPhase = (mPhase + 1) % 4;
          mElapsed = 0;
        end else begin
          mElapsed++;
        end
      end
    end
    if (cycles == 150000) begin
      mismatched++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      summary();
      $finish;
    end
  end

  // Per-cycle comparison against the model plus the safety rules
  always @(negedge clk) begin
    if (started) begin
      compared++;
      if (nsLamp !== expNs(mPhase) || ewLamp !== expEw(mPhase)) begin
        mismatched++;
        $display("FAIL %s cycle %0d: ns=%b ew=%b expected ns=%b ew=%b",
                 curTag, cycles, nsLamp, ewLamp, expNs(mPhase), expEw(mPhase));
      end
      compared++;
      if ($countones(nsLamp) != 1 || $countones(ewLamp) != 1) begin
        mismatched++;
        $display("FAIL R3 cycle %0d: ns=%b ew=%b expected one lamp each", cycles, nsLamp, ewLamp);
      end
      compared++;
      if (!(nsLamp[2] || ewLamp[2])) begin
        mismatched++;
        $display("FAIL R4 cycle %0d: ns=%b ew=%b expected one road red", cycles, nsLamp, ewLamp);
      end
    end
  end

  task automatic checkLamps(string tag, logic [2:0] eNs, logic [2:0] eEw);
    compared++;
    if (nsLamp !== eNs || ewLamp !== eEw) begin
      mismatched++;
      $display("FAIL %s: ns=%b ew=%b expected ns=%b ew=%b", tag, nsLamp, ewLamp, eNs, eEw);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : stim
    logic [2:0] holdNs, holdEw;
    waitCyc(5);
    checkLamps("R9 reset state", 3'b001, 3'b100);
    rst = 1'b0;

    // Divider source while the other sources toggle
    curTag = "R1/R2/R5/R10 divider";
    srcSel = 2'd0;
    for (int i = 0; i < 150; i++) begin
      extPulseIn = (i % 6) < 3;
      stepButton = (i % 20) < 10;
      waitCyc(1);
    end
    extPulseIn = 1'b0; stepButton = 1'b0;
    waitCyc(3);

    // Reset in the middle of a dwell
    curTag = "R9 mid-run reset";
    rst = 1'b1;
    waitCyc(2);
    checkLamps("R9 mid-run reset", 3'b001, 3'b100);
    rst = 1'b0;

    // External 1 Hz source
    curTag = "R1/R2/R6 external";
    srcSel = 2'd1;
    for (int i = 0; i < 20; i++) begin
      extPulseIn = 1'b1; waitCyc(3);
      extPulseIn = 1'b0; waitCyc(3);
    end
    curTag = "R6 held high";
    extPulseIn = 1'b1; waitCyc(30);
    extPulseIn = 1'b0; waitCyc(5);

    // Manual switch
    curTag = "R7 clean presses";
    srcSel = 2'd2;
    for (int i = 0; i < 14; i++) begin
      stepButton = 1'b1; waitCyc(8);
      stepButton = 1'b0; waitCyc(8);
    end
    curTag = "R7 short bounces";
    for (int i = 0; i < 10; i++) begin
      stepButton = 1'b1; waitCyc(2);
      stepButton = 1'b0; waitCyc(2);
    end
    waitCyc(6);
    curTag = "R7 bouncy press";
    for (int i = 0; i < 4; i++) begin
      stepButton = 1'b1; waitCyc(1);
      stepButton = 1'b0; waitCyc(1);
      stepButton = 1'b1; waitCyc(10);
      stepButton = 1'b0; waitCyc(1);
      stepButton = 1'b1; waitCyc(1);
      stepButton = 1'b0; waitCyc(10);
    end

    // Freeze
    curTag = "R8/R10 freeze";
    srcSel = 2'd3;
    waitCyc(2);
    holdNs = nsLamp; holdEw = ewLamp;
    for (int i = 0; i < 80; i++) begin
      extPulseIn = (i % 6) < 3;
      stepButton = (i % 16) < 8;
      waitCyc(1);
    end
    checkLamps("R8 lamps held under freeze", holdNs, holdEw);
    extPulseIn = 1'b0; stepButton = 1'b0;

    // Back to the divider
    curTag = "R2/R5 divider resumed";
    srcSel = 2'd0;
    waitCyc(90);

    summary();
    $finish;
  end

endmodule